// File: doc/BRIEF.md
# Serial-Loaded Static LCD Segment Driver

This block drives a direct-drive liquid crystal display, one output per segment plus one shared backplane. A host shifts segment data in serially: while the active-low select is asserted, each falling edge of the serial clock moves the register up one stage and takes a new bit from the serial input. A level-sensitive load input copies the register into a segment latch. The latch is transparent while load stays high, so it tracks the register even during shifting. When load is low, the latch holds.

A free-running display clock is divided by 256 to form the square-wave backplane. Each segment output is the latched bit XOR the backplane, registered on the display clock so that it has no glitches. A stored 1 therefore drives the segment in antiphase with the backplane, which turns it on. A stored 0 drives it in phase, which leaves it off.

A serial output, taken from a selectable register stage and updated on the rising serial clock edge, lets drivers be chained. Because the next driver samples on the falling edge, the link has half a clock of hold margin. The serial port is a fixed clocked shift interface with no back-pressure: every qualified falling edge consumes one bit, and the sender paces the data by gating the clock or the select.

Top module: `lcd_static_drv`

## Requirements
- R1: With `cs_n` low, each falling `sclk` edge loads `sdi` into stage 0 (index 0) and moves every stage k to k+1. After 38 shifts sent most significant bit first, the register equals the word that was sent.
- R2: With `cs_n` high, falling `sclk` edges leave the shift register unchanged.
- R3: While `load` is high, the segment latch equals the shift register, including the bits shifted in while `load` stays high.
- R4: While `load` is low, the segment latch keeps its value whatever is shifted in.
- R5: `sdo` changes only on rising `sclk` edges, taking the value of the selected stage at that edge. It is unchanged across falling edges.
- R6: `tap_sel` encoding: 0 selects index 29, 1 selects index 31, 2 selects index 33, and 3 selects index 37. These are stages 30, 32, 34 and 38, counted from 1.
- R7: `bp` is `clk_disp` divided by 256. After reset it is low, and it toggles on every 128th rising `clk_disp` edge.
- R8: On each rising `clk_disp` edge, `seg[i]` takes latch bit i XOR the new `bp` value. A latched 1 gives `seg[i]` = ~`bp`, and a latched 0 gives `seg[i]` = `bp`.
- R9: The synchronous active-high `rst` clears the divider, the shift register, `sdo`, the latch and `seg`. The divider, `seg` and the register need edges of their own clock while `rst` is high.
- R10: With a first driver's `sdo` wired to a second driver's `sdi`, shared `sclk`/`cs_n`/`load`, and tap 3 selected on the first driver, 76 shifts leave the first 38 bits sent in the second driver and the last 38 bits in the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_disp | input | 1 | Display clock, divided to form the backplane |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock: shift on fall, serial output on rise |
| cs_n | input | 1 | Active-low shift enable |
| sdi | input | 1 | Serial data input |
| load | input | 1 | High: segment latch transparent; low: latch holds |
| tap_sel | input | 2 | Stage feeding `sdo` (see R6) |
| sdo | output | 1 | Serial data output for chaining |
| bp | output | 1 | Backplane waveform |
| seg | output | SEG_N | Segment drive outputs |

## Verification
If the shift register or the latch holds a wrong bit, the affected segment runs in the wrong phase relative to `bp` from the first display clock edge after the latch settles. A wrong register stage also reaches `sdo` on the rising serial edge that selects it. A divider fault shows as a `bp` edge one or more display clocks away from the 128-cycle grid, and it corrupts every segment at that edge. The bench runs a reference model and compares `bp` and `seg` on every display clock, so any of these faults is caught within one cycle. It checks `sdo` just after every serial clock edge, on two chained drivers.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  typedef enum logic [1:0] {
    TAP_S30 = 2'd0,
    TAP_S32 = 2'd1,
    TAP_S34 = 2'd2,
    TAP_S38 = 2'd3
  } tap_sel_e;

  // Zero-based register index fed to the serial output for each selection.
  function automatic int unsigned tap_index(tap_sel_e s);
    case (s)
      TAP_S30: return 29;
      TAP_S32: return 31;
      TAP_S34: return 33;
      default: return 37;
    endcase
  endfunction

endpackage

// File: rtl/lcd_shift_chain.sv
module lcd_shift_chain #(
  parameter int N = 38
) (
  input  logic         sclk,
  input  logic         rst,
  input  logic         cs_n,
  input  logic         sdi,
  input  logic [1:0]   tap_sel,
  output logic [N-1:0] sr_o,
  output logic         sdo
);
  import lcd_drv_pkg::*;

  localparam int IW = $clog2(N);

  logic [N-1:0]  sr_q;
  logic [IW-1:0] tap_idx;
  logic          tap_bit;

  assign tap_idx = IW'(tap_index(tap_sel_e'(tap_sel)));
  assign tap_bit = sr_q[tap_idx];
  assign sr_o    = sr_q;

  always_ff @(negedge sclk) begin
    if (rst)        sr_q <= '0;
    else if (!cs_n) sr_q <= {sr_q[N-2:0], sdi};
  end

  always_ff @(posedge sclk) begin
    if (rst) sdo <= 1'b0;
    else     sdo <= tap_bit;
  end

  assert_shift_in_R1: assert property (@(negedge sclk) disable iff (rst)
    !cs_n |=> (sr_q[0] == $past(sdi)) && (sr_q[N-1:1] == $past(sr_q[N-2:0])));

  assert_hold_when_deselected_R2: assert property (@(negedge sclk) disable iff (rst)
    cs_n |=> $stable(sr_q));

  assert_sdo_from_tap_R5: assert property (@(posedge sclk) disable iff (rst)
    1'b1 |=> sdo == $past(tap_bit));

endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
  parameter int N = 38
) (
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_latch begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int DIV_LOG2 = 8
) (
  input  logic clk,
  input  logic rst,
  output logic bp_o,
  output logic bp_next_o
);
  localparam int                  MSB  = DIV_LOG2 - 1;
  localparam int                  HALF = 1 << MSB;
  localparam logic [DIV_LOG2-1:0] ONE  = 1;

  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  assign cnt_d     = cnt_q + ONE;
  assign bp_o      = cnt_q[MSB];
  assign bp_next_o = cnt_d[MSB];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // Checker: distance since the last backplane edge.
  logic [DIV_LOG2-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst)                     gap_q <= '0;
    else if (bp_next_o != bp_o)  gap_q <= '0;
    else                         gap_q <= gap_q + ONE;
  end

  assert_bp_half_period_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp_o) |-> gap_q == '0);

  assert_bp_gap_bound_R7: assert property (@(posedge clk) disable iff (rst)
    32'(gap_q) < HALF);

endmodule

// File: rtl/lcd_seg_out.sv
module lcd_seg_out #(
  parameter int N = 38
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lat,
  input  logic         bp_now,
  input  logic         bp_next,
  output logic [N-1:0] seg_o
);
  always_ff @(posedge clk) begin
    if (rst) seg_o <= '0;
    else     seg_o <= lat ^ {N{bp_next}};
  end

  assert_seg_phase_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (seg_o ^ {N{bp_now}}) == $past(lat));

endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv #(
  parameter int SEG_N    = 38,
  parameter int DIV_LOG2 = 8
) (
  input  logic             clk_disp,
  input  logic             rst,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             load,
  input  logic [1:0]       tap_sel,
  output logic             sdo,
  output logic             bp,
  output logic [SEG_N-1:0] seg
);
  logic [SEG_N-1:0] sr_w, lat_w;
  logic             bp_next_w;

  lcd_shift_chain #(.N(SEG_N)) u_shift (
    .sclk(sclk), .rst(rst), .cs_n(cs_n), .sdi(sdi),
    .tap_sel(tap_sel), .sr_o(sr_w), .sdo(sdo)
  );

  lcd_seg_latch #(.N(SEG_N)) u_latch (
    .rst(rst), .load(load), .d(sr_w), .q(lat_w)
  );

  lcd_bp_divider #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk_disp), .rst(rst), .bp_o(bp), .bp_next_o(bp_next_w)
  );

  lcd_seg_out #(.N(SEG_N)) u_out (
    .clk(clk_disp), .rst(rst), .lat(lat_w), .bp_now(bp),
    .bp_next(bp_next_w), .seg_o(seg)
  );

  assert_latch_follows_R3: assert property (@(posedge clk_disp) disable iff (rst)
    load |-> lat_w == sr_w);

  assert_latch_holds_R4: assert property (@(posedge clk_disp) disable iff (rst)
    !load && !$past(load) |-> $stable(lat_w));

endmodule

// File: tb/lcd_static_drv_tb.sv
module lcd_static_drv_tb;
  localparam int N = 38;

  logic clk_disp = 1'b0, rst = 1'b1, sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, load = 1'b0;
  logic [1:0] tsel0 = 2'd3, tsel1 = 2'd3;
  logic sdo0, sdo1, bp0, bp1;
  logic [N-1:0] seg0, seg1;

  always #10 clk_disp = ~clk_disp;

  lcd_static_drv u_dut (
    .clk_disp(clk_disp), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .load(load), .tap_sel(tsel0), .sdo(sdo0), .bp(bp0), .seg(seg0));

  lcd_static_drv u_nxt (
    .clk_disp(clk_disp), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdo0),
    .load(load), .tap_sel(tsel1), .sdo(sdo1), .bp(bp1), .seg(seg1));

  // Behavioural reference model
  logic [N-1:0] m_sr0 = '0, m_sr1 = '0, m_lat0 = '0, m_lat1 = '0;
  logic [N-1:0] m_seg0 = '0, m_seg1 = '0;
  logic m_sdo0 = 1'b0, m_sdo1 = 1'b0;
  int n_dclk = 0;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  function automatic int tapi(logic [1:0] s);
    case (s)
      2'd0: return 29;
      2'd1: return 31;
      2'd2: return 33;
      default: return 37;
    endcase
  endfunction

  function automatic logic exp_bp();
    return ((n_dclk >> 7) & 1) != 0;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk_disp) begin
    if (rst) begin
      n_dclk = 0; m_seg0 = '0; m_seg1 = '0;
    end else begin
      n_dclk++;
      m_seg0 = m_lat0 ^ {N{exp_bp()}};
      m_seg1 = m_lat1 ^ {N{exp_bp()}};
    end
  end

  always @(negedge clk_disp) begin
    if (!rst && !done) begin
      chk("R7 backplane u_dut", N'(bp0), N'(exp_bp()));
      chk("R7 backplane u_nxt", N'(bp1), N'(exp_bp()));
      chk("R8 segments u_dut", seg0, m_seg0);
      chk("R8 R10 segments u_nxt", seg1, m_seg1);
    end
  end

  task automatic follow();
    if (load) begin m_lat0 = m_sr0; m_lat1 = m_sr1; end
  endtask

  task automatic fall();
    @(negedge clk_disp);
    sclk = 1'b0;
    if (!cs_n) begin
      m_sr1 = {m_sr1[N-2:0], m_sdo0};
      m_sr0 = {m_sr0[N-2:0], sdi};
    end
    follow();
    #1;
    chk("R5 sdo held over fall u_dut", N'(sdo0), N'(m_sdo0));
  endtask

  task automatic rise();
    @(negedge clk_disp);
    sclk = 1'b1;
    m_sdo0 = m_sr0[tapi(tsel0)];
    m_sdo1 = m_sr1[tapi(tsel1)];
    #1;
    chk("R5 R6 sdo after rise u_dut", N'(sdo0), N'(m_sdo0));
    chk("R5 R10 sdo after rise u_nxt", N'(sdo1), N'(m_sdo1));
  endtask

  task automatic shift_bits(logic [2*N-1:0] v, int nb);
    for (int i = nb - 1; i >= 0; i--) begin
      sdi = v[i];
      fall();
      rise();
    end
  endtask

  task automatic set_load(logic v);
    @(negedge clk_disp);
    load = v;
    follow();
  endtask

  task automatic settle();
    repeat (2) @(negedge clk_disp);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk_disp);
    rst = 1'b1;
    repeat (3) begin
      @(negedge clk_disp) sclk = 1'b0;
      @(negedge clk_disp) sclk = 1'b1;
    end
    m_sr0 = '0; m_sr1 = '0; m_lat0 = '0; m_lat1 = '0; m_sdo0 = 1'b0; m_sdo1 = 1'b0;
    @(negedge clk_disp);
    rst = 1'b0;
    #1;
    chk("R9 reset sdo", N'(sdo0), '0);
    chk("R9 reset seg", seg0, '0);
    chk("R9 reset bp", N'(bp0), '0);
  endtask

  localparam logic [N-1:0] PAT_A = 38'h3A5C30E917;
  localparam logic [N-1:0] PAT_B = 38'h15A3C96F04;
  localparam logic [N-1:0] PAT_C = 38'h2F00C3A55A;

  initial begin
    do_reset();

    // R1/R4: shift with load low, segments unchanged; then pulse load
    cs_n = 1'b0;
    shift_bits({38'd0, PAT_A}, N);
    settle();
    chk("R4 latch held while shifting", seg0 ^ {N{bp0}}, '0);
    set_load(1'b1); set_load(1'b0);
    settle();
    chk("R1 R8 latched pattern A", seg0 ^ {N{bp0}}, PAT_A);

    // R2: deselected shifting is ignored
    cs_n = 1'b1;
    shift_bits({38'd0, PAT_B}, 10);
    set_load(1'b1); set_load(1'b0);
    settle();
    chk("R2 register held when deselected", seg0 ^ {N{bp0}}, PAT_A);

    // R6: tap selection with register held
    for (int t = 0; t < 4; t++) begin
      tsel0 = 2'(t);
      fall();
      rise();
      chk("R6 tap index", N'(sdo0), N'(PAT_A[tapi(2'(t))]));
    end
    tsel0 = 2'd3;

    // R3: transparent latch while shifting
    cs_n = 1'b0;
    set_load(1'b1);
    shift_bits({38'd0, 38'h15}, 5);
    settle();
    chk("R3 transparent latch", seg0 ^ {N{bp0}}, {PAT_A[N-6:0], 5'h15});
    set_load(1'b0);

    // R10: chain of two drivers
    shift_bits({PAT_B, PAT_C}, 2 * N);
    set_load(1'b1); set_load(1'b0);
    settle();
    chk("R10 first driver holds last word", seg0 ^ {N{bp0}}, PAT_C);
    chk("R10 second driver holds first word", seg1 ^ {N{bp1}}, PAT_B);

    // Chain with other taps on both drivers
    tsel1 = 2'd1;
    for (int t = 0; t < 3; t++) begin
      tsel0 = 2'(t);
      shift_bits({PAT_A, PAT_B}, 20);
    end
    set_load(1'b1); set_load(1'b0);

    // Let backplane run several periods
    repeat (700) @(negedge clk_disp);

    // R9: reset mid-run clears loaded data
    do_reset();
    settle();
    chk("R9 latch cleared after reset", seg0 ^ {N{bp0}}, '0);
    repeat (300) @(negedge clk_disp);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule